// File: doc/BRIEF.md
# Segmented Triggered Capture Buffer

This block stores short bursts of converter samples into on-chip block RAM. Software first arms it with a segment count between 1 and `MAX_SEGS`. Each external trigger after that captures one segment of `SEG_WORDS` sample words. Each word holds several parallel lanes of 12-bit samples. Successive segments are written back to back, so that all of them together make one composite record. Once the programmed number of segments has been stored, the buffer freezes and the host reads the composite record out through a synchronous port.

The trigger input is asynchronous. It goes through a two-flop synchronizer, and its rising edge is held pending until the next frame-boundary pulse. That pulse is derived from the converter's system reference and repeats periodically. Capture always starts on the boundary pulse, so the latency from the trigger to the data is fixed. After a segment completes, the block is re-armed in the same clock cycle, which keeps the retrigger time far below a trigger period of hundreds of microseconds. A trigger that arrives while a segment is pending or in progress is recorded in a sticky overrun flag and is otherwise ignored.

Top module: `seg_capture_buffer`

## Requirements
- R1: After reset, `st_code` is 0 and `seg_stored`, `overrun` and `rd_data` are all 0. The state codes are: idle 0, armed 1, waiting for frame pulse 2, capturing 3, full 4.
- R2: A one-cycle `arm` in the idle state moves the block to armed (code 1) and latches the target segment count from `seg_cfg`. A value of 0 is taken as 1, and values above `MAX_SEGS` are taken as `MAX_SEGS`.
- R3: A rising edge of `trig_async` that is first sampled at clock edge k moves the block from armed to waiting (code 2) at edge k+2. A trigger in the idle or full state has no effect.
- R4: In the waiting state, a `frame_pulse` sampled high moves the block to capturing (code 3) at that edge. A frame pulse in the armed state has no effect.
- R5: A segment stores exactly `SEG_WORDS` words and takes a word only on cycles where `smp_valid` is high. At the edge that stores the last word, `seg_stored` increments and the state goes to armed, or to full once the target count is reached.
- R6: The first word of a segment is the valid sample present in the cycle after the frame pulse was sampled. Word i of segment s is stored at address s*`SEG_WORDS`+i.
- R7: A trigger edge during the waiting or capturing state sets the sticky `overrun` flag and does not shorten, lengthen or restart the segment.
- R8: In the full state, `rd_en` with `rd_addr` returns the stored word on `rd_data` one cycle later. In any other state, or with `rd_en` low, `rd_data` is 0 one cycle later.
- R9: `clear` returns the block to idle from any state and zeroes `seg_stored` and `overrun` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and host clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | LANES*LANE_W | Parallel sample lanes, lane 0 in the low bits |
| smp_valid | input | 1 | Sample word strobe |
| trig_async | input | 1 | Asynchronous capture trigger |
| frame_pulse | input | 1 | Single-cycle frame-boundary pulse |
| arm | input | 1 | Start a new composite record |
| clear | input | 1 | Abort or release the record, back to idle |
| seg_cfg | input | CNT_W | Requested segments per record |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host word address |
| rd_data | output | LANES*LANE_W | Read word, one cycle after the strobe |
| st_code | output | 3 | Current state code |
| seg_stored | output | CNT_W | Segments stored in the current record |
| overrun | output | 1 | Sticky flag for a trigger during a pending or active segment |

## Verification
The state code changes two edges after the first edge that samples a trigger. It changes at the same edge that samples a frame pulse. `seg_stored` steps at the edge that stores the segment's last valid word, so with a steady valid strobe it steps exactly `SEG_WORDS` edges after the frame pulse. `rd_data` follows its read strobe by one edge. The bench drives inputs on the falling edge, samples there as well, and counts edges from each stimulus to the expected one. For the start of capture, it reads the stamp on the sample word one time unit after the falling edge that follows the frame pulse. Sample words carry a cycle stamp, so the readout shows both the address order and the exact starting cycle of every segment.

// File: rtl/seg_cap_pkg.sv
package seg_cap_pkg;

    localparam int LANE_W_DEF = 12;
    localparam int LANES_DEF  = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CAPT  = 3'd3,
        ST_FULL  = 3'd4
    } cap_state_e;

    // Bound a requested segment count into 1..maxv.
    function automatic int unsigned clamp_segs(int unsigned req, int unsigned maxv);
        if (req == 0)
            return 1;
        if (req > maxv)
            return maxv;
        return req;
    endfunction

endpackage

// File: rtl/segcap_trig_sync.sv
module segcap_trig_sync (
    input  logic clk,
    input  logic rst,
    input  logic trig_async,
    output logic trig_evt
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[1:0], trig_async};
    end

    // Rising edge seen on the second synchronizer stage.
    assign trig_evt = sh[1] & ~sh[2];
endmodule

// File: rtl/segcap_ctrl.sv
module segcap_ctrl
    import seg_cap_pkg::*;
#(
    parameter int SEG_WORDS = 128,
    parameter int MAX_SEGS  = 16,
    parameter int CNT_W     = 5,
    parameter int AW        = 11,
    localparam int WC_W     = (SEG_WORDS > 2) ? $clog2(SEG_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             clear,
    input  logic [CNT_W-1:0] seg_cfg,
    input  logic             trig_evt,
    input  logic             frame_pulse,
    input  logic             smp_valid,
    output cap_state_e       st,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [CNT_W-1:0] nstored,
    output logic [CNT_W-1:0] tgt,
    output logic             ovr
);
    logic [AW-1:0]   wptr;
    logic [WC_W-1:0] wcnt;
    logic            last_word;

    assign wr_en     = (st == ST_CAPT) && smp_valid;
    assign wr_addr   = wptr;
    assign last_word = (wcnt == WC_W'(SEG_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st      <= ST_IDLE;
            wptr    <= '0;
            wcnt    <= '0;
            nstored <= '0;
            ovr     <= 1'b0;
            if (rst)
                tgt <= CNT_W'(1);
        end else begin
            case (st)
                ST_IDLE: begin
                    if (arm) begin
                        tgt     <= CNT_W'(clamp_segs(int'(seg_cfg), MAX_SEGS));
                        wptr    <= '0;
                        wcnt    <= '0;
                        nstored <= '0;
                        st      <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (trig_evt)
                        st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (trig_evt)
                        ovr <= 1'b1;
                    if (frame_pulse)
                        st <= ST_CAPT;
                end
                ST_CAPT: begin
                    if (trig_evt)
                        ovr <= 1'b1;
                    if (smp_valid) begin
                        wptr <= wptr + AW'(1);
                        if (last_word) begin
                            wcnt    <= '0;
                            nstored <= nstored + CNT_W'(1);
                            st      <= ((nstored + CNT_W'(1)) == tgt) ? ST_FULL : ST_ARMED;
                        end else begin
                            wcnt <= wcnt + WC_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/segcap_ram.sv
module segcap_ram #(
    parameter int W     = 48,
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/seg_capture_buffer.sv
module seg_capture_buffer
    import seg_cap_pkg::*;
#(
    parameter int LANE_W    = LANE_W_DEF,
    parameter int LANES     = LANES_DEF,
    parameter int SEG_WORDS = 128,
    parameter int MAX_SEGS  = 16,
    localparam int WORD_W   = LANE_W * LANES,
    localparam int DEPTH    = SEG_WORDS * MAX_SEGS,
    localparam int AW       = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(MAX_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic              trig_async,
    input  logic              frame_pulse,
    input  logic              arm,
    input  logic              clear,
    input  logic [CNT_W-1:0]  seg_cfg,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [2:0]        st_code,
    output logic [CNT_W-1:0]  seg_stored,
    output logic              overrun
);
    logic              trig_evt;
    cap_state_e        st;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [CNT_W-1:0]  tgt;
    logic              rd_go;
    logic              rd_ok;
    logic [WORD_W-1:0] ram_q;

    segcap_trig_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .trig_async (trig_async),
        .trig_evt   (trig_evt)
    );

    segcap_ctrl #(
        .SEG_WORDS (SEG_WORDS),
        .MAX_SEGS  (MAX_SEGS),
        .CNT_W     (CNT_W),
        .AW        (AW)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .arm         (arm),
        .clear       (clear),
        .seg_cfg     (seg_cfg),
        .trig_evt    (trig_evt),
        .frame_pulse (frame_pulse),
        .smp_valid   (smp_valid),
        .st          (st),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .nstored     (seg_stored),
        .tgt         (tgt),
        .ovr         (overrun)
    );

    assign rd_go = rd_en && (st == ST_FULL);

    segcap_ram #(
        .W     (WORD_W),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (smp_data),
        .re    (rd_go),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_ok <= 1'b0;
        else
            rd_ok <= rd_go;
    end

    assign rd_data = rd_ok ? ram_q : '0;
    assign st_code = st;
endmodule

// File: rtl/segcap_checker.sv
module segcap_checker
    import seg_cap_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int WORD_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        st_code,
    input logic              trig_evt,
    input logic              frame_pulse,
    input logic              clear,
    input logic              overrun,
    input logic [WORD_W-1:0] rd_data,
    input logic [CNT_W-1:0]  seg_stored,
    input logic [CNT_W-1:0]  tgt
);
    a_r3_trig_to_wait: assert property (@(posedge clk) disable iff (rst)
        (st_code == ST_ARMED && trig_evt && !clear) |=> (st_code == ST_WAIT));

    a_r4_frame_starts: assert property (@(posedge clk) disable iff (rst)
        (st_code == ST_WAIT && frame_pulse && !clear) |=> (st_code == ST_CAPT));

    a_r4_no_frame_no_start: assert property (@(posedge clk) disable iff (rst)
        (st_code == ST_WAIT && !frame_pulse) |=> (st_code != ST_CAPT));

    a_r5_full_count: assert property (@(posedge clk) disable iff (rst)
        (st_code == ST_FULL) |-> (seg_stored == tgt));

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clear) |=> overrun);

    a_r8_read_zero: assert property (@(posedge clk) disable iff (rst)
        (st_code != ST_FULL) |=> (rd_data == '0));

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (st_code == ST_IDLE && seg_stored == '0 && !overrun));
endmodule

bind seg_capture_buffer segcap_checker #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .st_code     (st_code),
    .trig_evt    (trig_evt),
    .frame_pulse (frame_pulse),
    .clear       (clear),
    .overrun     (overrun),
    .rd_data     (rd_data),
    .seg_stored  (seg_stored),
    .tgt         (tgt)
);

// File: tb/seg_capture_buffer_bench.sv
`timescale 1ns/1ps
module seg_capture_buffer_bench;
    localparam int SW    = 16;
    localparam int MS    = 16;
    localparam int WW    = 48;
    localparam int AWB   = 8;
    localparam int CW    = 5;
    localparam int NREC  = 5;
    localparam int T_CFG [NREC] = '{3, 0, 16, 20, 2};
    localparam int T_EXP [NREC] = '{3, 1, 16, 16, 2};
    localparam int T_GAP [NREC] = '{0, 3, 0, 2, 5};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           trig_async = 1'b0;
    logic           frame_pulse = 1'b0;
    logic           arm = 1'b0;
    logic           clear = 1'b0;
    logic [CW-1:0]  seg_cfg = '0;
    logic           rd_en = 1'b0;
    logic [AWB-1:0] rd_addr = '0;
    logic [WW-1:0]  smp_data;
    logic           smp_valid;
    logic [WW-1:0]  rd_data;
    logic [2:0]     st_code;
    logic [CW-1:0]  seg_stored;
    logic           overrun;

    int cyc = 0;
    int gap = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    assign smp_data  = {16'h0, cyc};
    assign smp_valid = (gap == 0) || ((cyc % gap) != 0);

    seg_capture_buffer #(.SEG_WORDS(SW), .MAX_SEGS(MS)) u_seg_capture_buffer (
        .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
        .trig_async(trig_async), .frame_pulse(frame_pulse), .arm(arm),
        .clear(clear), .seg_cfg(seg_cfg), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .st_code(st_code), .seg_stored(seg_stored),
        .overrun(overrun)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_valid(int c, int g);
        return (g == 0) || ((c % g) != 0);
    endfunction

    function automatic int nth_valid(int c0, int i, int g);
        int n = 0;
        for (int c = c0; c < c0 + 4 * SW + 8; c++) begin
            if (is_valid(c, g)) begin
                if (n == i) return c;
                n++;
            end
        end
        return -1;
    endfunction

    task automatic pulse_arm(input int cfg);
        @(negedge clk); seg_cfg = CW'(cfg); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic do_trigger();
        @(negedge clk); trig_async = 1'b1;
        repeat (3) @(negedge clk);
        trig_async = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Returns the stamp of the first sample cycle of the segment.
    task automatic start_capture(output int first);
        @(negedge clk); frame_pulse = 1'b1;
        @(negedge clk); frame_pulse = 1'b0;
        #1 first = cyc;
    endtask

    task automatic read_word(input int a, output longint v);
        @(negedge clk); rd_en = 1'b1; rd_addr = AWB'(a);
        @(negedge clk); v = longint'(rd_data); rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int first;
        int fs [MS];
        longint v;
        int bad;
        int fa;
        longint fv, fe;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 st_code", st_code, 0);
        chk("R1 seg_stored", seg_stored, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 rd_data", rd_data, 0);

        // R8 read outside full state returns zero
        read_word(0, v);
        chk("R8 read in idle", v, 0);

        // R3 trigger in idle ignored; R4 frame pulse in armed ignored
        do_trigger();
        chk("R3 idle trigger ignored", st_code, 0);
        pulse_arm(1);
        chk("R2 armed", st_code, 1);
        start_capture(first);
        repeat (SW + 4) @(negedge clk);
        chk("R4 frame in armed ignored st", st_code, 1);
        chk("R4 frame in armed ignored seg", seg_stored, 0);

        // R3 exact trigger latency
        @(negedge clk); trig_async = 1'b1;
        @(negedge clk); chk("R3 edge k", st_code, 1);
        @(negedge clk); chk("R3 edge k+1", st_code, 1);
        @(negedge clk); chk("R3 edge k+2", st_code, 2);
        trig_async = 1'b0;
        repeat (3) @(negedge clk);
        // R7 trigger while waiting sets overrun
        do_trigger();
        chk("R7 overrun in wait", overrun, 1);
        chk("R7 still waiting", st_code, 2);
        // R4 capture start, R5 exact length with a trigger inside (R7)
        start_capture(first);
        chk("R4 capturing", st_code, 3);
        trig_async = 1'b1;
        repeat (SW - 1) @(negedge clk);
        chk("R5 not yet done", seg_stored, 0);
        chk("R7 segment not cut", st_code, 3);
        @(negedge clk);
        chk("R5 done at last word", seg_stored, 1);
        chk("R5 full at target", st_code, 4);
        chk("R7 overrun sticky", overrun, 1);
        trig_async = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 full trigger ignored", st_code, 4);
        read_word(0, v);
        chk("R6 first word", v, first);
        read_word(SW - 1, v);
        chk("R6 last word", v, first + SW - 1);
        @(negedge clk);
        chk("R8 no strobe gives zero", rd_data, 0);
        pulse_clear();
        chk("R9 clear st", st_code, 0);
        chk("R9 clear seg", seg_stored, 0);
        chk("R9 clear overrun", overrun, 0);

        // Table-driven composite records
        for (int r = 0; r < NREC; r++) begin
            gap = T_GAP[r];
            pulse_arm(T_CFG[r]);
            chk("R2 arm", st_code, 1);
            for (int s = 0; s < T_EXP[r]; s++) begin
                do_trigger();
                start_capture(fs[s]);
                repeat (3 * SW) @(negedge clk);
                chk("R5 segment count", seg_stored, s + 1);
                chk("R5 next state", st_code, (s == T_EXP[r] - 1) ? 4 : 1);
            end
            chk("R2 clamped count", seg_stored, T_EXP[r]);
            chk("R7 no overrun", overrun, 0);
            bad = 0; fa = 0; fv = 0; fe = 0;
            for (int a = 0; a < T_EXP[r] * SW; a++) begin
                longint e;
                read_word(a, v);
                e = nth_valid(fs[a / SW], a % SW, gap);
                if (v != e) begin
                    if (bad == 0) begin fa = a; fv = v; fe = e; end
                    bad++;
                end
            end
            if (bad != 0)
                $display("  R6 first mismatch addr=%0d got=%0d want=%0d", fa, fv, fe);
            chk("R6 R8 record contents", bad, 0);
            pulse_clear();
            chk("R9 back to idle", st_code, 0);
            gap = 0;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule